// File: doc/BRIEF.md
# Supply Fault Status and Battery Switchover Controller

This block watches four comparator flags and reports the state of the supply to the rest of the chip. Two flags describe the main supply: one shows it is above the upper warning level and one shows it is above the lower switchover level. The other two flags describe the internal core supply while the part runs from the battery: one shows it is above the high core level and one shows it is above the low core level. The flags come from analog circuits and are asynchronous. Each flag passes through a synchronizer on the slow clock before the block uses it.

From the synchronized flags the block forms a 3-bit status code. The code set is sparse: 000, 001, 010, 011 and 101. The block also drives a battery-select line, an ADC clock-halt line, a flash-write inhibit, a single-cycle interrupt on each move onto battery, and a reset request. The reset request follows a fixed countdown that starts once the core supply has collapsed.

The block does not act on the warning level alone. It returns to the main supply as soon as the switchover flag recovers. Software can read the status code but cannot write it.

Top module: `pwr_fail_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released with healthy flags, `status` reads 000 and `on_battery`, `batt_irq`, `flash_wr_inhibit`, `adc_clk_halt` and `reset_req` are all low.
- R2: A flag change that is set up before rising edge k shows on the registered outputs after rising edge k+2. This is two synchronizer stages plus one output register.
- R3: If `main_sw_ok` and `main_warn_ok` are both 1, `status` is 000.
- R4: If `main_sw_ok` is 1 and `main_warn_ok` is 0, `status` is 001. In this case `on_battery`, `adc_clk_halt`, `flash_wr_inhibit` and `reset_req` stay low.
- R5: `on_battery` is 1 exactly when the synchronized `main_sw_ok` is 0. It returns to 0 as soon as that flag is 1 again, whatever the core flags show.
- R6: On battery with `core_lo_ok` = 1, `status` is 010 if `core_hi_ok` = 1 and 011 if `core_hi_ok` = 0.
- R7: On battery with `core_lo_ok` = 0, `status` is 101 whatever `core_hi_ok` shows. Codes 100, 110 and 111 never appear.
- R8: `flash_wr_inhibit` is 1 exactly when `status` is 011 or 101.
- R9: `adc_clk_halt` equals `on_battery`. The halt does not depend on any other input.
- R10: `batt_irq` is high for one cycle, in the same cycle that `on_battery` first reads 1. The pulse repeats on every later move from main supply to battery.
- R11: `reset_req` rises on the fourth cycle after `status` first reads 101, counting with `RST_DELAY` = 4. It stays high while `status` remains 101. It falls one cycle after `status` leaves 101, and any later entry to 101 starts a full new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock (32 kHz domain) |
| rst | input | 1 | Synchronous active-high reset |
| main_warn_ok | input | 1 | Asynchronous flag: main supply above the warning level |
| main_sw_ok | input | 1 | Asynchronous flag: main supply above the switchover level |
| core_hi_ok | input | 1 | Asynchronous flag: core supply above the high core level |
| core_lo_ok | input | 1 | Asynchronous flag: core supply above the low core level |
| status | output | 3 | Read-only supply status code |
| on_battery | output | 1 | Battery power selected |
| batt_irq | output | 1 | One-cycle pulse on each entry to battery power |
| flash_wr_inhibit | output | 1 | Blocks flash writes while the core supply is weak |
| adc_clk_halt | output | 1 | Stops the ADC clock while on battery |
| reset_req | output | 1 | Reset request after the collapse countdown |

## Verification
The assertions check the relations between outputs on every cycle:
- no illegal code appears,
- the inhibit follows the weak-core codes,
- the ADC halt follows the battery select,
- the interrupt lasts one cycle and marks a rise of the battery select,
- a reset request is always preceded by at least four cycles of status 101.

Some behaviour only the bench scenarios can show. These are the exact three-edge latency from a flag change, the decode of every flag combination (including inconsistent ones), the cancelled countdown when the core supply recovers early, and the interrupt re-arming across repeated battery entries.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Status codes; 100 is deliberately unused.
  typedef enum logic [2:0] {
    ST_OK        = 3'b000,
    ST_LOW       = 3'b001,
    ST_BATT      = 3'b010,
    ST_BATT_WEAK = 3'b011,
    ST_CRIT      = 3'b101
  } pwr_code_e;

  localparam int unsigned N_FLAGS  = 4;
  localparam int unsigned F_WARN   = 0;
  localparam int unsigned F_SW     = 1;
  localparam int unsigned F_CORE_H = 2;
  localparam int unsigned F_CORE_L = 3;

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] tap [STAGES+1];

  assign tap[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap[s+1] <= RST_VAL;
      else     tap[s+1] <= tap[s];
    end
  end

  assign q = tap[STAGES];

endmodule

// File: rtl/pfc_decode.sv
module pfc_decode
  import pfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLAGS-1:0] flags,
  output logic [2:0]         status_q,
  output logic               batt_q,
  output logic               irq_q,
  output logic               inhibit_q,
  output logic               halt_q
);

  pwr_code_e code_d;
  logic      batt_d;

  always_comb begin
    batt_d = !flags[F_SW];
    if (flags[F_SW])          code_d = flags[F_WARN] ? ST_OK : ST_LOW;
    else if (!flags[F_CORE_L]) code_d = ST_CRIT;
    else if (flags[F_CORE_H]) code_d = ST_BATT;
    else                      code_d = ST_BATT_WEAK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= ST_OK;
      batt_q    <= 1'b0;
      irq_q     <= 1'b0;
      inhibit_q <= 1'b0;
      halt_q    <= 1'b0;
    end else begin
      status_q  <= code_d;
      batt_q    <= batt_d;
      irq_q     <= batt_d && !batt_q;
      inhibit_q <= (code_d == ST_BATT_WEAK) || (code_d == ST_CRIT);
      halt_q    <= batt_d;
    end
  end

endmodule

// File: rtl/pfc_rst_timer.sv
module pfc_rst_timer #(
  parameter int unsigned DELAY = 4,
  localparam int unsigned CNT_W = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic crit,
  output logic req_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !crit) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
      req_q <= (cnt_q == LAST);
    end
  end

endmodule

// File: rtl/pwr_fail_ctrl.sv
module pwr_fail_ctrl
  import pfc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_DELAY   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_warn_ok,
  input  logic       main_sw_ok,
  input  logic       core_hi_ok,
  input  logic       core_lo_ok,
  output logic [2:0] status,
  output logic       on_battery,
  output logic       batt_irq,
  output logic       flash_wr_inhibit,
  output logic       adc_clk_halt,
  output logic       reset_req
);

  logic [N_FLAGS-1:0] raw_flags;
  logic [N_FLAGS-1:0] sync_flags;

  always_comb begin
    raw_flags           = '0;
    raw_flags[F_WARN]   = main_warn_ok;
    raw_flags[F_SW]     = main_sw_ok;
    raw_flags[F_CORE_H] = core_hi_ok;
    raw_flags[F_CORE_L] = core_lo_ok;
  end

  pfc_sync #(
    .WIDTH  (N_FLAGS),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_flags),
    .q  (sync_flags)
  );

  pfc_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .flags    (sync_flags),
    .status_q (status),
    .batt_q   (on_battery),
    .irq_q    (batt_irq),
    .inhibit_q(flash_wr_inhibit),
    .halt_q   (adc_clk_halt)
  );

  pfc_rst_timer #(
    .DELAY(RST_DELAY)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .crit (status == ST_CRIT),
    .req_q(reset_req)
  );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] status,
  input logic       on_battery,
  input logic       batt_irq,
  input logic       flash_wr_inhibit,
  input logic       adc_clk_halt,
  input logic       reset_req
);

  a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
    (status == 3'b000) || (status == 3'b001) || (status == 3'b010) ||
    (status == 3'b011) || (status == 3'b101));

  a_r5_batt_code: assert property (@(posedge clk) disable iff (rst)
    on_battery == (status[1] || status[2]));

  a_r8_inhibit: assert property (@(posedge clk) disable iff (rst)
    flash_wr_inhibit == ((status == 3'b011) || (status == 3'b101)));

  a_r9_adc_halt: assert property (@(posedge clk) disable iff (rst)
    adc_clk_halt == on_battery);

  a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
    batt_irq |=> !batt_irq);

  a_r10_irq_edge: assert property (@(posedge clk) disable iff (rst)
    batt_irq |-> (on_battery && !$past(on_battery)));

  a_r11_req_code: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(status) == 3'b101));

  a_r11_req_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> ($past(status, 4) == 3'b101));

endmodule

bind pwr_fail_ctrl pfc_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .status          (status),
  .on_battery      (on_battery),
  .batt_irq        (batt_irq),
  .flash_wr_inhibit(flash_wr_inhibit),
  .adc_clk_halt    (adc_clk_halt),
  .reset_req       (reset_req)
);

// File: tb/test_pwr_fail_ctrl.sv
module test_pwr_fail_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] flags = 4'hF;   // [0] warn, [1] switch, [2] core high, [3] core low
  logic [2:0] status;
  logic       on_battery, batt_irq, flash_wr_inhibit, adc_clk_halt, reset_req;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [3:0] pipe [3];
  bit  prev_batt = 1'b0;
  int  run       = 0;

  always #4 clk = ~clk;

  pwr_fail_ctrl i_pwr_fail_ctrl (
    .clk(clk), .rst(rst),
    .main_warn_ok(flags[0]), .main_sw_ok(flags[1]),
    .core_hi_ok(flags[2]), .core_lo_ok(flags[3]),
    .status(status), .on_battery(on_battery), .batt_irq(batt_irq),
    .flash_wr_inhibit(flash_wr_inhibit), .adc_clk_halt(adc_clk_halt),
    .reset_req(reset_req)
  );

  function automatic logic [2:0] exp_code(input logic [3:0] f);
    if (f[1])       return f[0] ? 3'b000 : 3'b001;
    else if (!f[3]) return 3'b101;
    else if (f[2])  return 3'b010;
    else            return 3'b011;
  endfunction

  function automatic string code_req(input logic [2:0] c);
    case (c)
      3'b000:  return "R3";
      3'b001:  return "R4";
      3'b101:  return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // At a falling edge: compare against the flags applied three steps ago (R2),
  // then apply a new flag set.
  task automatic step(input logic [3:0] f);
    logic [2:0] c;
    bit         b;
    bit         exp_rst;
    @(negedge clk);
    c       = exp_code(pipe[2]);
    b       = !pipe[2][1];
    exp_rst = (run >= 4);
    run     = (c == 3'b101) ? run + 1 : 0;
    chk({"R2 ", code_req(c)}, status, c);
    chk("R5 on_battery", {2'b0, on_battery}, {2'b0, b});
    chk("R9 adc_clk_halt", {2'b0, adc_clk_halt}, {2'b0, b});
    chk("R8 flash_wr_inhibit", {2'b0, flash_wr_inhibit},
        {2'b0, (c == 3'b011) || (c == 3'b101)});
    chk("R10 batt_irq", {2'b0, batt_irq}, {2'b0, b && !prev_batt});
    chk("R11 reset_req", {2'b0, reset_req}, {2'b0, exp_rst});
    prev_batt = b;
    pipe[2] = pipe[1];
    pipe[1] = pipe[0];
    pipe[0] = f;
    flags   = f;
  endtask

  task automatic hold(input logic [3:0] f, input int n);
    for (int i = 0; i < n; i++) step(f);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) pipe[i] = 4'hF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 status", status, 3'b000);
    chk("R1 outputs", {1'b0, on_battery | batt_irq, flash_wr_inhibit | adc_clk_halt | reset_req},
        3'b000);
    rst = 1'b0;

    hold(4'hF, 4);               // R3 healthy
    hold(4'b1110, 5);            // R4 warning only
    hold(4'b1100, 5);            // R6 battery, core good, irq R10
    hold(4'b1000, 5);            // R6 battery weak core
    hold(4'b0000, 10);           // R7 collapse, R11 reset fires
    hold(4'b1100, 3);            // recovery clears reset
    hold(4'b0100, 3);            // R7 inconsistent core flags, cancelled countdown
    hold(4'b1100, 2);
    hold(4'b0000, 4);            // R11 exactly at boundary
    hold(4'b1111, 3);            // R5 return to main
    for (int k = 0; k < 4; k++) begin   // R10 re-arm
      hold(4'b1100, 2);
      hold(4'b1111, 2);
    end
    hold(4'b1101, 3);            // R5 switch flag dominates

    for (int seg = 0; seg < 400; seg++) begin
      logic [3:0] f;
      int         len;
      f   = 4'($urandom % 16);
      if (($urandom % 4) == 0) f = 4'b0000;
      len = 1 + int'($urandom % 8);
      hold(f, len);
    end
    hold(4'hF, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule